// File: doc/BRIEF.md
# Prefetch-Stage Branch Target Redirector

This block sits in the early-decode stage of an instruction prefetch pipeline. Every cycle it looks at the instruction being decoded and checks whether it is a PC-relative unconditional branch. If it is, the block adds the branch displacement to the prefetch address of that instruction, in the same cycle. It then sends the target back to the fetch address generator together with a flush. The flush throws away the prefetch stream that is in flight, and fetching starts again at the target. The execution pipeline plays no part in this. The branch is still passed downstream, so the target instruction can enter execution right behind it, and a taken branch costs one slot.

A branch is recognised by its opcode: the upper byte `dec_opcode[15:8]` is compared with the parameter `BR_MAJOR` (default 8'h60).
- When the low byte `dec_opcode[7:0]` is not zero, it is the displacement, taken as a signed 8-bit value and sign-extended.
- When the low byte is zero, the displacement is the 16-bit extension word `dec_ext`, also sign-extended.

Once a redirect is issued, the instructions that reach decode in the next `SHADOW` cycles belong to the abandoned stream. They are discarded. This way a redirect from an older instruction always wins over a younger one.

The control is a two-state machine:
- **ST_SCAN** is the normal state. Valid instructions are checked and forwarded.
- **ST_SQUASH** discards everything arriving at decode while a down-counter runs.

The transitions are:
- **T_HIT** (ST_SCAN → ST_SQUASH) happens when a valid branch is decoded. The counter is loaded with `SHADOW-1`.
- **T_DRAIN** (ST_SQUASH → ST_SQUASH) happens while the counter is not zero. The counter counts down by one.
- **T_RESUME** (ST_SQUASH → ST_SCAN) happens when the counter reaches zero.
- **T_STAY** (ST_SCAN → ST_SCAN) happens on any cycle without a valid branch.

Top module: `bt_redirect`

## Requirements
- R1: In ST_SCAN, a valid instruction with `dec_opcode[15:8]` == 8'h60 raises `redir_valid` and `fetch_flush` combinationally in the same cycle it is decoded.
- R2: When `dec_opcode[7:0]` is non-zero, `redir_target` equals `dec_pc` plus `dec_opcode[7:0]` taken as a signed 8-bit value, sign-extended, modulo 2^AW. Negative displacements are included.
- R3: When `dec_opcode[7:0]` is zero, `redir_target` equals `dec_pc` plus `dec_ext` taken as a signed 16-bit value, sign-extended, modulo 2^AW.
- R4: Neither `redir_valid` nor `fetch_flush` is raised for an instruction whose upper opcode byte is not 8'h60, or for any cycle with `dec_valid` low.
- R5: The cycle after a redirect, `fwd_valid` is 1 and `fwd_opcode`, `fwd_ext` and `fwd_pc` carry the branch that caused the redirect.
- R6: For `SHADOW` cycles (default 1) after a redirect, instructions at decode raise no redirect and are not forwarded: `fwd_valid` is 0 one cycle later. A second branch directly behind the first is therefore discarded.
- R7: During and right after reset, `redir_valid`, `fetch_flush` and `fwd_valid` are 0, and the block starts in ST_SCAN.
- R8: A valid instruction decoded in ST_SCAN appears one cycle later on `fwd_valid`/`fwd_opcode`/`fwd_ext`/`fwd_pc`. A cycle with `dec_valid` low gives `fwd_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Instruction present at decode |
| dec_opcode | input | 16 | First opcode word |
| dec_ext | input | 16 | Extension word (long displacement) |
| dec_pc | input | AW | Prefetch address of the instruction |
| redir_valid | output | 1 | Redirect request to the fetch address generator |
| redir_target | output | AW | New fetch address |
| fetch_flush | output | 1 | Discard the in-flight prefetch stream |
| fwd_valid | output | 1 | Instruction forwarded downstream |
| fwd_opcode | output | 16 | Forwarded opcode |
| fwd_ext | output | 16 | Forwarded extension word |
| fwd_pc | output | AW | Forwarded prefetch address |

## Verification
Two functions can meet in one cycle: forwarding the branch that caused a redirect, and discarding the wrong-path instruction, possibly a second branch, that arrives at decode right behind it. The bench provokes this by sending branches back to back and by sending a branch directly followed by a plain instruction. A behavioural reference model tracks how many discard cycles remain. On every cycle it compares the redirect, target and flush, and the forwarded fields from the cycle before. The model only accepts outputs in which the older branch keeps its redirect and the younger one leaves no trace.

// File: rtl/bt_pkg.sv
package bt_pkg;
    typedef enum logic {
        ST_SCAN   = 1'b0,
        ST_SQUASH = 1'b1
    } bt_state_e;

    localparam logic [7:0] BR_MAJOR_DEFAULT = 8'h60;
endpackage

// File: rtl/bt_decode.sv
module bt_decode #(
    parameter int         AW       = 32,
    parameter logic [7:0] BR_MAJOR = 8'h60
) (
    input  logic [15:0]   opcode,
    input  logic [15:0]   ext,
    output logic          is_branch,
    output logic [AW-1:0] disp
);
    localparam int SHORT_PAD = AW - 8;
    localparam int LONG_PAD  = AW - 16;

    logic short_zero;

    always_comb begin
        is_branch  = (opcode[15:8] == BR_MAJOR);
        short_zero = (opcode[7:0] == 8'h00);
        if (short_zero)
            disp = {{LONG_PAD{ext[15]}}, ext};
        else
            disp = {{SHORT_PAD{opcode[7]}}, opcode[7:0]};
    end
endmodule

// File: rtl/bt_target.sv
module bt_target #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] disp,
    output logic [AW-1:0] target
);
    always_comb target = base + disp;
endmodule

// File: rtl/bt_squash_fsm.sv
module bt_squash_fsm
    import bt_pkg::*;
#(
    parameter int SHADOW = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic is_branch,
    output logic live,
    output logic take
);
    localparam int CW = (SHADOW > 1) ? $clog2(SHADOW) : 1;

    bt_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_SCAN: begin
                if (in_valid && is_branch) begin      // T_HIT
                    state_d = ST_SQUASH;
                    cnt_d   = CW'(SHADOW - 1);
                end                                   // else T_STAY
            end
            ST_SQUASH: begin
                if (cnt_q == '0)
                    state_d = ST_SCAN;                // T_RESUME
                else
                    cnt_d = cnt_q - 1'b1;             // T_DRAIN
            end
            default: state_d = ST_SCAN;
        endcase
    end

    // outputs
    always_comb begin
        live = (state_q == ST_SCAN) && in_valid;
        take = live && is_branch;
    end

    // R6: a redirect always opens a discard window of at least one cycle
    p_no_back_to_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !live);
endmodule

// File: rtl/bt_redirect.sv
module bt_redirect
    import bt_pkg::*;
#(
    parameter int         AW       = 32,
    parameter int         SHADOW   = 1,
    parameter logic [7:0] BR_MAJOR = BR_MAJOR_DEFAULT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [15:0]   dec_opcode,
    input  logic [15:0]   dec_ext,
    input  logic [AW-1:0] dec_pc,
    output logic          redir_valid,
    output logic [AW-1:0] redir_target,
    output logic          fetch_flush,
    output logic          fwd_valid,
    output logic [15:0]   fwd_opcode,
    output logic [15:0]   fwd_ext,
    output logic [AW-1:0] fwd_pc
);
    logic          is_branch;
    logic [AW-1:0] disp;
    logic          live;
    logic          take;

    bt_decode #(.AW(AW), .BR_MAJOR(BR_MAJOR)) u_dec (
        .opcode    (dec_opcode),
        .ext       (dec_ext),
        .is_branch (is_branch),
        .disp      (disp)
    );

    bt_target #(.AW(AW)) u_add (
        .base   (dec_pc),
        .disp   (disp),
        .target (redir_target)
    );

    bt_squash_fsm #(.SHADOW(SHADOW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (dec_valid),
        .is_branch (is_branch),
        .live      (live),
        .take      (take)
    );

    always_comb begin
        redir_valid = take;
        fetch_flush = take;
    end

    // downstream stage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid  <= 1'b0;
            fwd_opcode <= '0;
            fwd_ext    <= '0;
            fwd_pc     <= '0;
        end else begin
            fwd_valid  <= live;
            fwd_opcode <= dec_opcode;
            fwd_ext    <= dec_ext;
            fwd_pc     <= dec_pc;
        end
    end

    // R5: the branch that redirects is itself forwarded next cycle
    p_branch_forwarded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> (fwd_valid && fwd_pc == $past(dec_pc)));

    // R4: no redirect without a valid instruction
    p_redir_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !redir_valid);

    // R8: forwarded instructions come from a valid decode slot
    p_fwd_from_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(dec_valid));
endmodule

// File: tb/sim_bt_redirect.sv
`timescale 1ns/1ps
module sim_bt_redirect;
    localparam int AW     = 32;
    localparam int SHADOW = 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dec_valid;
    logic [15:0]   dec_opcode;
    logic [15:0]   dec_ext;
    logic [AW-1:0] dec_pc;
    logic          redir_valid;
    logic [AW-1:0] redir_target;
    logic          fetch_flush;
    logic          fwd_valid;
    logic [15:0]   fwd_opcode;
    logic [15:0]   fwd_ext;
    logic [AW-1:0] fwd_pc;

    always #4 clk = ~clk;

    bt_redirect #(.AW(AW), .SHADOW(SHADOW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_opcode(dec_opcode),
        .dec_ext(dec_ext), .dec_pc(dec_pc),
        .redir_valid(redir_valid), .redir_target(redir_target),
        .fetch_flush(fetch_flush),
        .fwd_valid(fwd_valid), .fwd_opcode(fwd_opcode),
        .fwd_ext(fwd_ext), .fwd_pc(fwd_pc)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference model state
    int            sq_left = 0;
    bit            exp_fv  = 0;
    logic [15:0]   exp_op  = '0;
    logic [15:0]   exp_ex  = '0;
    logic [AW-1:0] exp_pc  = '0;
    string         exp_tag = "R7";

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [15:0] op,
                        input logic [15:0] ex, input logic [AW-1:0] pc,
                        input string tag);
        bit            live, br, rd;
        logic [AW-1:0] d, tgt;
        @(negedge clk);
        // registered outputs from the previous decode slot
        check(exp_tag, "fwd_valid", 64'(fwd_valid), 64'(exp_fv));
        if (exp_fv) begin
            check(exp_tag, "fwd_pc", 64'(fwd_pc), 64'(exp_pc));
            check(exp_tag, "fwd_opcode", 64'(fwd_opcode), 64'(exp_op));
            check(exp_tag, "fwd_ext", 64'(fwd_ext), 64'(exp_ex));
        end
        dec_valid = v; dec_opcode = op; dec_ext = ex; dec_pc = pc;
        #1;
        live = v && (sq_left == 0);
        br   = (op[15:8] == 8'h60);
        rd   = live && br;
        if (op[7:0] == 8'h00) d = AW'($signed(ex));
        else                  d = AW'($signed(op[7:0]));
        tgt = pc + d;
        check(tag, "redir_valid", 64'(redir_valid), 64'(rd));
        check(tag, "fetch_flush", 64'(fetch_flush), 64'(rd));
        if (rd) check(tag, "redir_target", 64'(redir_target), 64'(tgt));
        // advance model
        if (rd)               sq_left = SHADOW;
        else if (sq_left > 0) sq_left--;
        exp_fv = live; exp_op = op; exp_ex = ex; exp_pc = pc; exp_tag = tag;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; dec_valid = 0; dec_opcode = '0; dec_ext = '0; dec_pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7 reset state
        check("R7", "redir_valid", 64'(redir_valid), 64'd0);
        check("R7", "fetch_flush", 64'(fetch_flush), 64'd0);
        check("R7", "fwd_valid", 64'(fwd_valid), 64'd0);
        rst_n = 1;
        step(1, 16'h4E71, 16'h0000, 32'h0000_1000, "R4");  // non-branch
        step(1, 16'h6010, 16'h1234, 32'h0000_1002, "R1");  // short fwd, R2
        step(1, 16'h4E71, 16'h0000, 32'h0000_1004, "R6");  // stale, R5 fwd
        step(1, 16'h60FE, 16'h0000, 32'h0000_2000, "R2");  // negative disp
        step(1, 16'h6020, 16'h0000, 32'h0000_2002, "R6");  // back-to-back
        step(1, 16'h6000, 16'h8000, 32'h0001_0000, "R3");  // long negative
        step(0, 16'h0000, 16'h0000, 32'h0000_0000, "R6");  // shadow, idle
        step(0, 16'h6010, 16'h0000, 32'h0000_4000, "R4");  // branch, invalid
        step(1, 16'h6000, 16'h0100, 32'h0000_3000, "R3");  // long positive
        step(1, 16'h7001, 16'h0000, 32'h0000_3100, "R6");
        step(1, 16'h6100, 16'h0000, 32'h0000_3104, "R4");  // other major
        step(1, 16'h1234, 16'h5678, 32'h0000_3106, "R8");
        step(1, 16'h6080, 16'h0000, 32'h0000_0040, "R2");  // -128 wraps
        step(0, 16'h0000, 16'h0000, 32'h0000_0000, "R8");
        step(0, 16'h0000, 16'h0000, 32'h0000_0000, "R8");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule